// File: doc/BRIEF.md
# Bypass-Capable Output Sub-Switch for a Mesh Wormhole Router

This block is one output port of a five-port mesh router (four neighbour directions plus the local core). Up to four other input ports compete for the output link. Traffic that takes the normal path is held in a small FIFO per input. A round-robin allocator then picks a packet, and a registered traversal stage drives the link, so there are three register stages between an input and the link.

Some inputs have a fixed bypass path to this output. The path may go straight, turn right or turn left, and the `BYP_MASK` parameter marks which inputs have one. A configuration that only bypasses along one dimension sets only the straight input. A header flit on a bypass input still goes through the pipeline once, and it wins allocation ahead of every buffered requester. Once that header has left and the pipeline is empty, the body and tail flits of the same packet go from the input pins to the output pins in the same cycle, with no register on the way. No separate control wires set up this path: the header flit sets it up. The tail flit releases it.

Route computation is done outside the block. Each input supplies a signal saying whether its current flit wants this output. Virtual channels and credits are outside the scope of this block.

Top module: `byp_outsw`

## Requirements
- R1: A flit is `{type[1:0], payload[DW-1:0]}` with the type in the two top bits. The type codes are 2'b01 header, 2'b00 body, 2'b10 tail and 2'b11 single-flit packet. Type bit 0 marks a packet start and type bit 1 marks a packet end.
- R2: Assume the output is free and `out_ready` is high. A header accepted in cycle t then appears on the output in cycle t+3.
- R3: The flits of one packet reach the output in order. Flits of different packets never interleave, and no flit is lost or duplicated.
- R4: Among buffered (non-bypass) headers, the winner is the first requester at or after a round-robin pointer. The pointer moves to the input after the winner only when that winner's tail leaves.
- R5: A header at the head of a bypass-enabled input's FIFO wins allocation over every buffered header from a non-bypass input in the same cycle.
- R6: Bypass mode applies when a bypass input owns the output, its header has left, and the traversal register and its FIFO are both empty. In that mode, a body or tail flit presented on that input appears on the output in the same cycle.
- R7: While any input owns the output, no other input's flit reaches the output. Flits from other inputs are buffered and are sent in order after the owner's tail has left.
- R8: A single-flit packet both claims and releases the output.
- R9: A bypass header may take the output from a non-bypass packet that holds the output but has not yet sent its header. A packet whose header has already left is never interrupted.
- R10: While `out_ready` is low, the output flit is held unchanged. In bypass mode, the owning input's `in_ready` follows `out_ready` in the same cycle.
- R11: Reset clears ownership, FIFOs and the traversal register. After reset `out_valid` is 0 and every `in_ready` is 1.
- R12: An input's `in_ready` is low when its FIFO (depth `FIFO_DEPTH`) is full. A flit held on that input is accepted once space frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Per-input flit valid |
| in_req | input | N_IN | Per-input: the current flit is routed to this output |
| in_flit | input | N_IN*(DW+2) | Per-input flits, input i in slice [i*(DW+2) +: DW+2] |
| in_ready | output | N_IN | Per-input accept |
| out_valid | output | 1 | Output link flit valid |
| out_flit | output | DW+2 | Output link flit |
| out_ready | input | 1 | Output link accepts the flit |

## Verification
The bound assertions check four things on every cycle:
- No FIFO is written while full.
- A stalled registered output holds its flit.
- A bypass owner's `in_ready` drops with `out_ready`.
- A started packet keeps its owner until release, and a grant made while a bypass header is waiting goes to a bypass input.

Several behaviours can only be shown by the bench's scripted scenarios:
- The exact three-cycle buffered latency.
- Bypassed body flits arriving with zero added cycles.
- The round-robin order across several inputs.
- Takeover of an output that was reserved but not yet started.
- Complete, non-interleaved flit order at the link.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10,
    FT_SOLO = 2'b11
  } ftype_e;

  // type bit 0: a packet begins with this flit
  function automatic logic opens_pkt(input logic [1:0] t);
    return t[0];
  endfunction

  // type bit 1: a packet ends with this flit
  function automatic logic closes_pkt(input logic [1:0] t);
    return t[1];
  endfunction

endpackage

// File: rtl/bsw_fifo.sv
module bsw_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/bsw_alloc.sv
module bsw_alloc #(
  parameter int              N    = 4,
  parameter logic [N-1:0]    MASK = 4'b0001,
  localparam int             IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          vld,
  output logic [IW-1:0] idx
);
  logic [N-1:0] pri, use_vec;

  function automatic logic [IW-1:0] first_from(input logic [N-1:0] v,
                                               input logic [IW-1:0] p);
    logic [IW-1:0] r;
    logic          hit;
    int            j;
    r   = '0;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      j = (int'(p) + k) % N;
      if (!hit && v[j]) begin
        r   = IW'(j);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    pri     = req & MASK;
    use_vec = (|pri) ? pri : req;
    vld     = |req;
    idx     = first_from(use_vec, ptr);
  end
endmodule

// File: rtl/byp_outsw.sv
module byp_outsw #(
  parameter int                N_IN       = 4,
  parameter int                DW         = 8,
  parameter int                FIFO_DEPTH = 4,
  parameter logic [N_IN-1:0]   BYP_MASK   = 4'b0001,
  localparam int               FW         = DW + 2,
  localparam int               IW         = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      in_valid,
  input  logic [N_IN-1:0]      in_req,
  input  logic [N_IN*FW-1:0]   in_flit,
  output logic [N_IN-1:0]      in_ready,
  output logic                 out_valid,
  output logic [FW-1:0]        out_flit,
  input  logic                 out_ready
);
  import bsw_pkg::*;

  logic [FW-1:0]   in_f   [N_IN];
  logic [FW-1:0]   head_f [N_IN];
  logic [N_IN-1:0] q_empty, q_full, q_push, q_pop;
  logic [N_IN-1:0] hdr_at_head, byp_cand, arb_req;

  // ownership and traversal state
  logic            own_vld, own_started, own_byp;
  logic [IW-1:0]   own_idx, rr_ptr;
  logic            out_vq;
  logic [FW-1:0]   out_dq;

  // named events
  logic            ev_pop, ev_grant, ev_release, byp_live, byp_fire, preempt_ok;
  logic [IW-1:0]   arb_idx;
  logic [FW-1:0]   pop_f;

  function automatic logic [IW-1:0] ptr_after(input logic [IW-1:0] i);
    return (i == IW'(N_IN - 1)) ? '0 : i + 1'b1;
  endfunction

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign in_f[i]        = in_flit[i*FW +: FW];
    assign hdr_at_head[i] = !q_empty[i] && opens_pkt(head_f[i][FW-1:FW-2]);
    assign q_pop[i]       = ev_pop && (own_idx == IW'(i));
    assign q_push[i]      = in_valid[i] && in_req[i] && !q_full[i] &&
                            !(byp_live && own_idx == IW'(i));
    assign in_ready[i]    = (byp_live && own_idx == IW'(i)) ? out_ready : !q_full[i];

    bsw_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[i]),
      .din   (in_f[i]),
      .pop   (q_pop[i]),
      .dout  (head_f[i]),
      .empty (q_empty[i]),
      .full  (q_full[i])
    );
  end

  assign byp_cand = hdr_at_head & BYP_MASK;
  assign pop_f    = head_f[own_idx];

  assign ev_pop     = own_vld && !q_empty[own_idx] && (!out_vq || out_ready);
  assign byp_live   = own_vld && own_byp && own_started && q_empty[own_idx] && !out_vq;
  assign byp_fire   = byp_live && in_valid[own_idx] && in_req[own_idx] && out_ready;
  assign preempt_ok = own_vld && !own_started && !own_byp && !ev_pop;
  assign arb_req    = !own_vld ? hdr_at_head : (preempt_ok ? byp_cand : '0);

  bsw_alloc #(.N(N_IN), .MASK(BYP_MASK)) u_alloc (
    .req (arb_req),
    .ptr (rr_ptr),
    .vld (ev_grant),
    .idx (arb_idx)
  );

  assign ev_release = (ev_pop && closes_pkt(pop_f[FW-1:FW-2])) ||
                      (byp_fire && closes_pkt(in_f[own_idx][FW-1:FW-2]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld     <= 1'b0;
      own_started <= 1'b0;
      own_byp     <= 1'b0;
      own_idx     <= '0;
      rr_ptr      <= '0;
    end else if (ev_grant) begin
      own_vld     <= 1'b1;
      own_started <= 1'b0;
      own_idx     <= arb_idx;
      own_byp     <= BYP_MASK[arb_idx];
    end else if (ev_release) begin
      own_vld     <= 1'b0;
      own_started <= 1'b0;
      rr_ptr      <= ptr_after(own_idx);
    end else if (ev_pop) begin
      own_started <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vq <= 1'b0;
      out_dq <= '0;
    end else if (ev_pop) begin
      out_vq <= 1'b1;
      out_dq <= pop_f;
    end else if (out_ready) begin
      out_vq <= 1'b0;
    end
  end

  assign out_valid = byp_live ? (in_valid[own_idx] && in_req[own_idx]) : out_vq;
  assign out_flit  = byp_live ? in_f[own_idx] : out_dq;
endmodule

// File: rtl/bsw_chk.sv
module bsw_chk #(
  parameter int N_IN = 4,
  parameter int FW   = 10,
  parameter int IW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            own_vld,
  input logic            own_started,
  input logic            own_byp,
  input logic [IW-1:0]   own_idx,
  input logic            ev_grant,
  input logic            ev_release,
  input logic            byp_live,
  input logic [N_IN-1:0] byp_cand,
  input logic [N_IN-1:0] q_push,
  input logic [N_IN-1:0] q_full,
  input logic [N_IN-1:0] in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [FW-1:0]   out_flit
);
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push & q_full) == '0);

  a_r10_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !byp_live |=> out_valid && $stable(out_flit));

  a_r10_byp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    byp_live && !out_ready |-> !in_ready[own_idx]);

  a_r9_no_cut_in: assert property (@(posedge clk) disable iff (!rst_n)
    own_vld && own_started && !ev_release |=> own_vld && own_idx == $past(own_idx));

  a_r7_lock_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    byp_live |-> !ev_grant);

  a_r5_byp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant && (byp_cand != '0) |=> own_byp);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> !own_vld);
endmodule

bind byp_outsw bsw_chk #(.N_IN(N_IN), .FW(FW), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .own_vld     (own_vld),
  .own_started (own_started),
  .own_byp     (own_byp),
  .own_idx     (own_idx),
  .ev_grant    (ev_grant),
  .ev_release  (ev_release),
  .byp_live    (byp_live),
  .byp_cand    (byp_cand),
  .q_push      (q_push),
  .q_full      (q_full),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_flit    (out_flit)
);

// File: tb/byp_outsw_tb.sv
module byp_outsw_tb;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int FW = DW + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N-1:0]      in_req = '0;
  logic [FW-1:0]     drv [N];
  logic [N-1:0]      in_ready;
  logic              out_valid;
  logic [FW-1:0]     out_flit;
  logic              out_ready = 1'b1;
  logic [N*FW-1:0]   in_flit;

  always #10 clk = ~clk;

  assign in_flit = {drv[3], drv[2], drv[1], drv[0]};

  byp_outsw u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_req(in_req),
    .in_flit(in_flit), .in_ready(in_ready), .out_valid(out_valid),
    .out_flit(out_flit), .out_ready(out_ready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [FW-1:0] log_f [64];
  int            log_c [64];
  int            log_n = 0;
  logic [FW-1:0] exp_f [64];
  int            exp_c [64];
  string         exp_t [64];
  int            exp_n = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && log_n < 64) begin
      log_f[log_n] = out_flit;
      log_c[log_n] = cyc;
      log_n++;
    end
  end

  // type codes: 01 header, 00 body, 10 tail, 11 single
  function automatic logic [FW-1:0] mk(input logic [1:0] t, input int src, input int seq);
    return {t, 4'(src), 4'(seq)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic put(input int i, input logic [FW-1:0] f);
    in_valid[i] = 1'b1;
    in_req[i]   = 1'b1;
    drv[i]      = f;
  endtask

  task automatic idle(input int i);
    in_valid[i] = 1'b0;
    in_req[i]   = 1'b0;
  endtask

  task automatic expect_out(input logic [FW-1:0] f, input int c, input string tag);
    exp_f[exp_n] = f;
    exp_c[exp_n] = c;
    exp_t[exp_n] = tag;
    exp_n++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R3 watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int k;
    for (int i = 0; i < N; i++) drv[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R11 in_ready after reset", int'(in_ready), 15);

    // S1: buffered three-flit packet on input 2 (R1, R2, R3)
    tick; k = cyc;
    put(2, mk(2'b01, 2, 0)); tick;
    put(2, mk(2'b00, 2, 1)); tick;
    put(2, mk(2'b10, 2, 2)); tick;
    idle(2);
    expect_out(mk(2'b01, 2, 0), k + 3, "R1 R2 header latency");
    expect_out(mk(2'b00, 2, 1), k + 4, "R3 body follows");
    expect_out(mk(2'b10, 2, 2), k + 5, "R3 tail follows");
    repeat (8) tick;

    // S2: bypass on input 0, input 1 blocked meanwhile (R6, R7)
    k = cyc;
    put(0, mk(2'b01, 0, 0)); tick; idle(0);
    repeat (3) tick;
    put(0, mk(2'b00, 0, 1)); put(1, mk(2'b01, 1, 0)); tick;
    put(0, mk(2'b00, 0, 2)); put(1, mk(2'b00, 1, 1)); tick;
    put(0, mk(2'b10, 0, 3)); put(1, mk(2'b10, 1, 2)); tick;
    idle(0); idle(1);
    expect_out(mk(2'b01, 0, 0), k + 3, "R2 bypass header via pipeline");
    expect_out(mk(2'b00, 0, 1), k + 4, "R6 bypass body zero cycles");
    expect_out(mk(2'b00, 0, 2), k + 5, "R6 bypass body zero cycles");
    expect_out(mk(2'b10, 0, 3), k + 6, "R6 bypass tail zero cycles");
    expect_out(mk(2'b01, 1, 0), k + 9, "R7 blocked header after lock");
    expect_out(mk(2'b00, 1, 1), k + 10, "R7 blocked body");
    expect_out(mk(2'b10, 1, 2), k + 11, "R7 blocked tail");
    repeat (8) tick;

    // S3: bypass header beats buffered header favoured by pointer (R5, R8)
    k = cyc;
    put(0, mk(2'b11, 0, 4)); put(2, mk(2'b11, 2, 4)); tick;
    idle(0); idle(2);
    expect_out(mk(2'b11, 0, 4), k + 3, "R5 bypass priority");
    expect_out(mk(2'b11, 2, 4), k + 5, "R8 single claims and releases");
    repeat (8) tick;

    // S4: round robin among buffered inputs, pointer at 3 (R4)
    k = cyc;
    put(1, mk(2'b11, 1, 5)); put(2, mk(2'b11, 2, 5)); put(3, mk(2'b11, 3, 5)); tick;
    idle(1); idle(2); idle(3);
    expect_out(mk(2'b11, 3, 5), k + 3, "R4 rr first");
    expect_out(mk(2'b11, 1, 5), k + 5, "R4 rr wrap");
    expect_out(mk(2'b11, 2, 5), k + 7, "R4 rr third");
    repeat (8) tick;

    // S5: stall, takeover of a reserved packet, bypass backpressure (R9, R10)
    k = cyc;
    out_ready = 1'b0;
    put(3, mk(2'b11, 3, 6)); tick;
    idle(3); put(2, mk(2'b01, 2, 6)); tick;
    put(2, mk(2'b00, 2, 7)); tick;
    put(2, mk(2'b10, 2, 8)); tick;
    idle(2); put(0, mk(2'b01, 0, 6)); tick;
    idle(0);
    @(negedge clk);
    chk(out_valid && out_flit == mk(2'b11, 3, 6), "R10 stall holds flit", int'(out_flit), int'(mk(2'b11, 3, 6)));
    tick;
    @(negedge clk);
    chk(out_valid && out_flit == mk(2'b11, 3, 6), "R10 stall still holds", int'(out_flit), int'(mk(2'b11, 3, 6)));
    tick;
    out_ready = 1'b1; tick;
    tick;
    out_ready = 1'b0; put(0, mk(2'b10, 0, 7));
    @(negedge clk);
    chk(in_ready[0] == 1'b0, "R10 bypass in_ready follows out_ready", int'(in_ready[0]), 0);
    chk(out_valid && out_flit == mk(2'b10, 0, 7), "R10 bypass flit shown", int'(out_flit), int'(mk(2'b10, 0, 7)));
    tick;
    out_ready = 1'b1; tick;
    idle(0);
    expect_out(mk(2'b11, 3, 6), k + 7, "R10 stalled single");
    expect_out(mk(2'b01, 0, 6), k + 8, "R9 bypass takes reserved output");
    expect_out(mk(2'b10, 0, 7), k + 10, "R10 bypass tail after stall");
    expect_out(mk(2'b01, 2, 6), k + 13, "R9 reserved packet resumes");
    expect_out(mk(2'b00, 2, 7), k + 14, "R9 reserved body");
    expect_out(mk(2'b10, 2, 8), k + 15, "R9 reserved tail");
    repeat (8) tick;

    // S6: FIFO full backpressure (R12)
    out_ready = 1'b0;
    put(3, mk(2'b11, 3, 9)); put(1, mk(2'b01, 1, 9)); tick;
    idle(3); put(1, mk(2'b00, 1, 10)); tick;
    put(1, mk(2'b00, 1, 11)); tick;
    put(1, mk(2'b00, 1, 12)); tick;
    put(1, mk(2'b10, 1, 13));
    @(negedge clk);
    chk(in_ready[1] == 1'b0, "R12 full input not ready", int'(in_ready[1]), 0);
    tick; tick;
    out_ready = 1'b1;
    for (int w = 0; w < 10; w++) begin
      if (in_valid[1]) begin
        @(negedge clk);
        if (in_ready[1]) begin
          tick;
          idle(1);
        end else begin
          tick;
        end
      end
    end
    expect_out(mk(2'b11, 3, 9), -1, "R12 order single");
    expect_out(mk(2'b01, 1, 9), -1, "R12 order header");
    expect_out(mk(2'b00, 1, 10), -1, "R12 order body");
    expect_out(mk(2'b00, 1, 11), -1, "R12 order body");
    expect_out(mk(2'b00, 1, 12), -1, "R12 order body");
    expect_out(mk(2'b10, 1, 13), -1, "R12 held tail accepted");
    repeat (12) tick;

    // compare link log with expectations (R3 order, no extra flits)
    chk(log_n == exp_n, "R3 flit count", log_n, exp_n);
    for (int e = 0; e < exp_n; e++) begin
      if (e < log_n) begin
        chk(log_f[e] == exp_f[e], exp_t[e], int'(log_f[e]), int'(exp_f[e]));
        if (exp_c[e] >= 0)
          chk(log_c[e] == exp_c[e], {exp_t[e], " cycle"}, log_c[e], exp_c[e]);
      end else begin
        chk(1'b0, exp_t[e], -1, int'(exp_f[e]));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule